// File: doc/BRIEF.md
# Three-Level IO Page Table Walker

This block turns an IO virtual address presented by one of sixteen DMA streams into a physical address. Each stream owns a two-bit mode word and four root pointers, all loaded through a small register write port. In pass-through mode the address comes back unchanged. In walk mode the top bits of the virtual address pick one of the stream's root pointers. The walker then reads a first-level entry and a second-level entry from memory and builds the physical address from the second entry's frame number and the 16 KiB page offset. Every other mode setting, and every missing pointer or entry, produces a fault response with a cause code.

One walk is in flight at a time. A request is accepted only when the walker is idle. The response is held until the consumer takes it, and only then is the next request accepted. Memory is reached through a single-outstanding read port. The walker issues a one-cycle read strobe with a byte address, and the memory answers later with one 64-bit word and a valid pulse.

Top module: `iopt_walker`

## Requirements
- R1: During and right after reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: When a stream's mode word has bit 8 set and bit 7 clear, the response returns the virtual address unchanged, with cause 0 and no memory read.
- R3: When a stream's mode word has bits 7 and 8 both set or both clear, the response carries cause 1 and no memory read is made.
- R4: In walk mode (bit 7 set, bit 8 clear), a root index va[39:36] above 3 gives cause 2 with no memory read.
- R5: In walk mode, a selected root pointer with bit 31 clear gives cause 3 with no memory read.
- R6: The first read goes to byte address (root[30:0] << 12) + va[35:25]*8.
- R7: A first-level entry with bit 0 clear ends the walk after exactly one read, with cause 4.
- R8: The second read goes to byte address (entry1[39:14] << 14) + va[24:14]*8.
- R9: A second-level entry with bit 0 clear ends the walk after exactly two reads, with cause 5.
- R10: A completed walk makes exactly two reads and returns {entry2[39:14], va[13:0]} with cause 0.
- R11: From acceptance until the response handshake, `req_ready_o` stays 0. While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response fields hold steady. The handshake returns the walker to idle on the next cycle.
- R12: A word-aligned write at 0x100 + 4*s loads stream s's mode word. A word-aligned write at 0x200 + 16*s + 4*r loads root pointer r of stream s. Misaligned or unmapped write addresses change nothing.
- R13: `rsp_fault_o` is 1 exactly when the cause is nonzero, and a fault response carries a physical address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 12 | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_stream_i | input | 4 | Requesting stream |
| req_va_i | input | 40 | IO virtual address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_pa_o | output | 40 | Physical address |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_cause_o | output | 3 | Cause: 0 ok, 1 mode, 2 range, 3 root, 4 level 1, 5 level 2 |
| mem_req_o | output | 1 | One-cycle table read strobe |
| mem_addr_o | output | 44 | Table entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry |

## Verification
The walker holds only a latched request and a walk state, so a corrupted state shows up on the first transaction that follows it. A wrong mode decode or root selection changes the cause code or the read count of that same response. A wrong index slice moves the read address on the very strobe that uses it. A stuck state shows as `req_ready_o` failing to return one cycle after the handshake. The bench sweeps every stream against many address patterns and checks each response, every read address and the read count against a model of the tables that is computed from the address alone.

// File: rtl/iopt_walker_pkg.sv
package iopt_walker_pkg;
  localparam int PAGE_BITS      = 14;
  localparam int IDX_BITS       = 11;
  localparam int ENT_BYTES_LOG  = 3;
  localparam int ROOT_LSB       = PAGE_BITS + 2 * IDX_BITS;
  localparam int ROOT_SHIFT     = 12;
  localparam int TCR_XLATE_BIT  = 7;
  localparam int TCR_BYPASS_BIT = 8;
  localparam int ROOT_VALID_BIT = 31;
  localparam int TCR_BASE       = 'h100;
  localparam int ROOT_BASE      = 'h200;

  typedef enum logic [1:0] {MODE_BAD, MODE_PASS, MODE_WALK} mode_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_MODE    = 3'd1,
    CAUSE_RANGE   = 3'd2,
    CAUSE_NO_ROOT = 3'd3,
    CAUSE_NO_L1   = 3'd4,
    CAUSE_NO_L2   = 3'd5
  } cause_e;

  typedef enum logic [2:0] {ST_IDLE, ST_DECODE, ST_L1, ST_L2, ST_RESP} state_e;
endpackage

// File: rtl/iopt_cfg_regs.sv
module iopt_cfg_regs
  import iopt_walker_pkg::*;
#(
  parameter int NS     = 16,
  parameter int NR     = 4,
  parameter int CFG_AW = 12,
  localparam int SW    = $clog2(NS),
  localparam int RW    = $clog2(NR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [SW-1:0]     rd_stream_i,
  input  logic [RW-1:0]     rd_root_i,
  output logic              tcr_xlate_o,
  output logic              tcr_bypass_o,
  output logic [31:0]       root_o
);
  localparam int ROOT_STRIDE = 4 * NR;

  logic [1:0]  tcr_q  [NS];
  logic [31:0] root_q [NS][NR];

  logic [CFG_AW-1:0] tcr_off, root_off;
  logic              tcr_hit, root_hit;
  logic [SW-1:0]     tcr_s, root_s;
  logic [RW-1:0]     root_r;

  assign tcr_off  = cfg_addr_i - CFG_AW'(TCR_BASE);
  assign root_off = cfg_addr_i - CFG_AW'(ROOT_BASE);
  assign tcr_hit  = cfg_we_i && (cfg_addr_i[1:0] == 2'b00) &&
                    (cfg_addr_i >= CFG_AW'(TCR_BASE)) && (tcr_off < CFG_AW'(4 * NS));
  assign root_hit = cfg_we_i && (cfg_addr_i[1:0] == 2'b00) &&
                    (cfg_addr_i >= CFG_AW'(ROOT_BASE)) &&
                    (root_off < CFG_AW'(ROOT_STRIDE * NS));
  assign tcr_s    = tcr_off[2 +: SW];
  assign root_r   = root_off[2 +: RW];
  assign root_s   = root_off[2 + RW +: SW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++) begin
        tcr_q[s] <= '0;
        for (int r = 0; r < NR; r++) root_q[s][r] <= '0;
      end
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (tcr_hit && tcr_s == SW'(s))
          tcr_q[s] <= {cfg_wdata_i[TCR_BYPASS_BIT], cfg_wdata_i[TCR_XLATE_BIT]};
        for (int r = 0; r < NR; r++)
          if (root_hit && root_s == SW'(s) && root_r == RW'(r))
            root_q[s][r] <= cfg_wdata_i;
      end
    end
  end

  assign tcr_xlate_o  = tcr_q[rd_stream_i][0];
  assign tcr_bypass_o = tcr_q[rd_stream_i][1];
  assign root_o       = root_q[rd_stream_i][rd_root_i];
endmodule

// File: rtl/iopt_decode.sv
module iopt_decode
  import iopt_walker_pkg::*;
#(
  parameter int NR     = 4,
  parameter int VA_W   = 40,
  parameter int MEM_AW = 44
) (
  input  logic                   tcr_xlate_i,
  input  logic                   tcr_bypass_i,
  input  logic [31:0]            root_i,
  input  logic [VA_W-ROOT_LSB-1:0] root_field_i,
  input  logic [IDX_BITS-1:0]    l1_idx_i,
  output mode_e                  mode_o,
  output logic                   root_in_range_o,
  output logic                   root_valid_o,
  output logic [MEM_AW-1:0]      l1_addr_o
);
  always_comb begin
    unique case ({tcr_bypass_i, tcr_xlate_i})
      2'b10:   mode_o = MODE_PASS;
      2'b01:   mode_o = MODE_WALK;
      default: mode_o = MODE_BAD;
    endcase
  end

  assign root_in_range_o = int'(root_field_i) < NR;
  assign root_valid_o    = root_i[ROOT_VALID_BIT];
  assign l1_addr_o = MEM_AW'({root_i[ROOT_VALID_BIT-1:0], {ROOT_SHIFT{1'b0}}}) +
                     MEM_AW'({l1_idx_i, {ENT_BYTES_LOG{1'b0}}});
endmodule

// File: rtl/iopt_walk_fsm.sv
module iopt_walk_fsm
  import iopt_walker_pkg::*;
#(
  parameter int SW     = 4,
  parameter int VA_W   = 40,
  parameter int PA_W   = 40,
  parameter int MEM_AW = 44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SW-1:0]     req_stream_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_pa_o,
  output cause_e            rsp_cause_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  input  mode_e             mode_i,
  input  logic              root_in_range_i,
  input  logic              root_valid_i,
  input  logic [MEM_AW-1:0] l1_addr_i,
  output logic [SW-1:0]     stream_o,
  output logic [VA_W-1:0]   va_o
);
  state_e            state_q;
  logic [SW-1:0]     stream_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   pa_q;
  cause_e            cause_q;
  logic              mem_req_q;
  logic [MEM_AW-1:0] mem_addr_q;
  logic [MEM_AW-1:0] l2_addr;
  logic              unused_rdata;

  assign l2_addr = MEM_AW'({mem_rdata_i[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}}) +
                   MEM_AW'({va_q[PAGE_BITS +: IDX_BITS], {ENT_BYTES_LOG{1'b0}}});
  assign unused_rdata = ^{mem_rdata_i[63:PA_W], mem_rdata_i[PAGE_BITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      stream_q   <= '0;
      va_q       <= '0;
      pa_q       <= '0;
      cause_q    <= CAUSE_NONE;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
    end else begin
      mem_req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          stream_q <= req_stream_i;
          va_q     <= req_va_i;
          state_q  <= ST_DECODE;
        end
        ST_DECODE: begin
          pa_q    <= '0;
          state_q <= ST_RESP;
          unique case (mode_i)
            MODE_PASS: begin
              pa_q    <= va_q[PA_W-1:0];
              cause_q <= CAUSE_NONE;
            end
            MODE_WALK: begin
              if (!root_in_range_i)  cause_q <= CAUSE_RANGE;
              else if (!root_valid_i) cause_q <= CAUSE_NO_ROOT;
              else begin
                mem_req_q  <= 1'b1;
                mem_addr_q <= l1_addr_i;
                state_q    <= ST_L1;
              end
            end
            default: cause_q <= CAUSE_MODE;
          endcase
        end
        ST_L1: if (mem_rvalid_i) begin
          if (!mem_rdata_i[0]) begin
            cause_q <= CAUSE_NO_L1;
            state_q <= ST_RESP;
          end else begin
            mem_req_q  <= 1'b1;
            mem_addr_q <= l2_addr;
            state_q    <= ST_L2;
          end
        end
        ST_L2: if (mem_rvalid_i) begin
          if (!mem_rdata_i[0]) cause_q <= CAUSE_NO_L2;
          else begin
            pa_q    <= {mem_rdata_i[PA_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
            cause_q <= CAUSE_NONE;
          end
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_pa_o    = pa_q;
  assign rsp_cause_o = cause_q;
  assign mem_req_o   = mem_req_q;
  assign mem_addr_o  = mem_addr_q;
  assign stream_o    = stream_q;
  assign va_o        = va_q;
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_walker_pkg::*;
#(
  parameter int NS     = 16,
  parameter int NR     = 4,
  parameter int CFG_AW = 12,
  parameter int VA_W   = 40,
  parameter int PA_W   = 40,
  parameter int MEM_AW = 44,
  localparam int SW    = $clog2(NS),
  localparam int RW    = $clog2(NR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SW-1:0]     req_stream_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic              rsp_fault_o,
  output logic [2:0]        rsp_cause_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i
);
  logic              tcr_xlate, tcr_bypass, root_in_range, root_valid;
  logic [31:0]       root_word;
  logic [SW-1:0]     cur_stream;
  logic [VA_W-1:0]   cur_va;
  logic [MEM_AW-1:0] l1_addr;
  mode_e             mode;
  cause_e            cause;

  iopt_cfg_regs #(.NS(NS), .NR(NR), .CFG_AW(CFG_AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .rd_stream_i (cur_stream),
    .rd_root_i   (cur_va[ROOT_LSB +: RW]),
    .tcr_xlate_o (tcr_xlate),
    .tcr_bypass_o(tcr_bypass),
    .root_o      (root_word)
  );

  iopt_decode #(.NR(NR), .VA_W(VA_W), .MEM_AW(MEM_AW)) u_dec (
    .tcr_xlate_i    (tcr_xlate),
    .tcr_bypass_i   (tcr_bypass),
    .root_i         (root_word),
    .root_field_i   (cur_va[VA_W-1:ROOT_LSB]),
    .l1_idx_i       (cur_va[PAGE_BITS + IDX_BITS +: IDX_BITS]),
    .mode_o         (mode),
    .root_in_range_o(root_in_range),
    .root_valid_o   (root_valid),
    .l1_addr_o      (l1_addr)
  );

  iopt_walk_fsm #(.SW(SW), .VA_W(VA_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_stream_i, .req_va_i, .req_ready_o,
    .rsp_valid_o, .rsp_ready_i, .rsp_pa_o,
    .rsp_cause_o    (cause),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .mode_i         (mode),
    .root_in_range_i(root_in_range),
    .root_valid_i   (root_valid),
    .l1_addr_i      (l1_addr),
    .stream_o       (cur_stream),
    .va_o           (cur_va)
  );

  assign rsp_cause_o = cause;
  assign rsp_fault_o = (cause != CAUSE_NONE);
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
  parameter int PA_W   = 40,
  parameter int MEM_AW = 44
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [PA_W-1:0]   rsp_pa_o,
  input logic              rsp_fault_o,
  input logic [2:0]        rsp_cause_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  logic [1:0] rd_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rd_seen <= '0;
    else if (req_valid_i && req_ready_o) rd_seen <= '0;
    else if (mem_req_o && rd_seen != 2'd3) rd_seen <= rd_seen + 2'd1;
  end

  AST_READ_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> rd_seen < 2'd2);  // R10
  AST_ENTRY_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);  // R6
  AST_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o && !rsp_valid_o);  // R11
  AST_IDLE_XOR_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));  // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);  // R11
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o) &&
    $stable(rsp_cause_o) && $stable(rsp_fault_o));  // R11
  AST_RSP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o && req_ready_o);  // R11
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == '0 && rsp_cause_o != 3'd0);  // R13
endmodule

bind iopt_walker iopt_walker_chk #(.PA_W(PA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .rsp_valid_o, .rsp_ready_i,
  .rsp_pa_o, .rsp_fault_o, .rsp_cause_o, .mem_req_o, .mem_addr_o
);

// File: tb/sim_iopt_walker.sv
module sim_iopt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NR = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [11:0] cfg_addr_i;
  logic [31:0] cfg_wdata_i;
  logic        req_valid_i, req_ready_o;
  logic [3:0]  req_stream_i;
  logic [39:0] req_va_i;
  logic        rsp_valid_o, rsp_ready_i, rsp_fault_o;
  logic [39:0] rsp_pa_o;
  logic [2:0]  rsp_cause_o;
  logic        mem_req_o, mem_rvalid_i;
  logic [43:0] mem_addr_o;
  logic [63:0] mem_rdata_i;

  int vec_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;

  logic [1:0]  m_tcr  [NS];
  logic [31:0] m_root [NS][NR];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  iopt_walker u0 (.*);

  function automatic logic [63:0] ent(input logic [43:0] a);
    logic [25:0] fr;
    fr = 26'(a[31:3] * 29 + 5);
    return {12'h000, 12'hfff, fr, 12'h000, 1'b1, ((a[13:3] % 11'd5) != 11'd0)};
  endfunction

  // memory model: answers two cycles after seeing a strobe
  logic [1:0]  m_wait;
  logic [43:0] m_addr, rd_prev, rd_last;
  int          rd_cnt;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wait <= '0; m_addr <= '0; mem_rvalid_i <= 1'b0; mem_rdata_i <= '0;
      rd_cnt <= 0; rd_prev <= '0; rd_last <= '0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (mem_req_o) begin
        m_wait <= 2'd2; m_addr <= mem_addr_o;
        rd_cnt <= rd_cnt + 1; rd_prev <= rd_last; rd_last <= mem_addr_o;
      end else if (m_wait != 2'd0) begin
        m_wait <= m_wait - 2'd1;
        if (m_wait == 2'd1) begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i  <= ent(m_addr);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        err_cnt++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run(input int s, input logic [39:0] va, input int hold, input string pre);
    logic [39:0] exp_pa = '0;
    logic [2:0]  exp_cause = 3'd0;
    int          exp_rd = 0;
    logic [43:0] a1 = '0, a2 = '0;
    logic [63:0] e1, e2;
    logic [31:0] rt;
    string       tag;
    int          c0;
    logic [39:0] pa0;
    logic [2:0]  ca0;
    if (m_tcr[s] == 2'b10) begin
      exp_pa = va; tag = "R2";
    end else if (m_tcr[s] != 2'b01) begin
      exp_cause = 3'd1; tag = "R3";
    end else if (va[39:36] > 4'd3) begin
      exp_cause = 3'd2; tag = "R4";
    end else begin
      rt = m_root[s][va[37:36]];
      if (!rt[31]) begin
        exp_cause = 3'd3; tag = "R5";
      end else begin
        a1 = (44'(rt[30:0]) << 12) + 44'(va[35:25]) * 44'd8;
        e1 = ent(a1); exp_rd = 1;
        if (!e1[0]) begin
          exp_cause = 3'd4; tag = "R7";
        end else begin
          a2 = (44'(e1[39:14]) << 14) + 44'(va[24:14]) * 44'd8;
          e2 = ent(a2); exp_rd = 2;
          if (!e2[0]) begin
            exp_cause = 3'd5; tag = "R9";
          end else begin
            exp_pa = {e2[39:14], va[13:0]}; tag = "R10";
          end
        end
      end
    end
    tag = {pre, tag};

    @(negedge clk_i);
    c0 = rd_cnt;
    chk(req_ready_o == 1'b1, {tag, " R11 idle before request"}, 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_stream_i = 4'(s); req_va_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) begin
      chk(req_ready_o == 1'b0, {tag, " R11 busy during walk"}, 64'(req_ready_o), 64'd0);
      @(negedge clk_i);
    end
    pa0 = rsp_pa_o; ca0 = rsp_cause_o;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk_i);
      chk(rsp_valid_o && rsp_pa_o == pa0 && rsp_cause_o == ca0 && !req_ready_o,
          {tag, " R11 response held"}, 64'(rsp_pa_o), 64'(pa0));
    end
    chk(rsp_pa_o == exp_pa, {tag, " pa"}, 64'(rsp_pa_o), 64'(exp_pa));
    chk(rsp_cause_o == exp_cause, {tag, " cause"}, 64'(rsp_cause_o), 64'(exp_cause));
    chk(rsp_fault_o == (exp_cause != 3'd0), {tag, " R13 fault flag"},
        64'(rsp_fault_o), 64'(exp_cause != 3'd0));
    chk(rd_cnt - c0 == exp_rd, {tag, " read count"}, 64'(rd_cnt - c0), 64'(exp_rd));
    if (exp_rd == 1)
      chk(rd_last == a1, {tag, " R6 level-1 address"}, 64'(rd_last), 64'(a1));
    if (exp_rd == 2) begin
      chk(rd_prev == a1, {tag, " R6 level-1 address"}, 64'(rd_prev), 64'(a1));
      chk(rd_last == a2, {tag, " R8 level-2 address"}, 64'(rd_last), 64'(a2));
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    chk(!rsp_valid_o && req_ready_o, {tag, " R11 idle after handoff"},
        64'({rsp_valid_o, req_ready_o}), 64'b01);
  endtask

  function automatic logic [39:0] mk_va(input int s, input int n);
    return {4'(n % 6), 11'((n * 37 + s * 5) % 2048), 11'((n * 101 + s * 3) % 2048),
            14'((n * 613) % 16384)};
  endfunction

  initial begin
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    req_valid_i = 1'b0; req_stream_i = '0; req_va_i = '0; rsp_ready_i = 1'b0;
    for (int s = 0; s < NS; s++) begin
      m_tcr[s] = 2'b00;
      for (int r = 0; r < NR; r++) m_root[s][r] = '0;
    end
    #(3 * CLK_PERIOD);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 reset state",
        64'({req_ready_o, rsp_valid_o, mem_req_o}), 64'b100);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 after reset",
        64'({req_ready_o, rsp_valid_o, mem_req_o}), 64'b100);

    // R12: program every stream through the decoded offsets
    for (int s = 0; s < NS; s++) begin
      case (s % 4)
        0:       m_tcr[s] = 2'b00;
        3:       m_tcr[s] = (s < 8) ? 2'b10 : 2'b11;
        default: m_tcr[s] = 2'b01;
      endcase
      cfg_wr(12'(32'h100 + 4 * s), {23'd0, m_tcr[s], 7'd0});
      for (int r = 0; r < NR; r++) begin
        m_root[s][r] = {((s + r) % 3) != 0, 31'(s * 64 + r * 4 + 1)};
        cfg_wr(12'(32'h200 + 16 * s + 4 * r), m_root[s][r]);
      end
    end

    for (int s = 0; s < NS; s++)
      for (int n = 0; n < 24; n++)
        run(s, mk_va(s, n), n % 3, "");

    // R12: misaligned and unmapped writes change nothing
    cfg_wr(12'h10D, 32'h0000_0080);
    cfg_wr(12'h140, 32'h0000_0080);
    cfg_wr(12'h201, 32'h0000_0000);
    cfg_wr(12'h300, 32'h0000_0000);
    run(3, 40'h12_3456_789A, 1, "R12 ignored ");
    run(1, {4'd0, 11'd7, 11'd9, 14'h1234}, 0, "R12 ignored ");
    // R12: decoded writes take effect
    m_tcr[3] = 2'b01;
    cfg_wr(12'h10C, 32'h0000_0080);
    m_root[3][1] = 32'h8000_0123;
    cfg_wr(12'h234, 32'h8000_0123);
    for (int n = 0; n < 12; n++)
      run(3, {4'd1, 11'((n * 211) % 2048), 11'((n * 59) % 2048), 14'(n * 97)}, n % 2,
          "R12 decoded ");

    summary();
    $finish;
  end
endmodule